// File: doc/BRIEF.md
# Start-Triggered Count Sequencer

The sequencer is a small clocked controller. It holds a binary counter and two single-bit flags, named B and C. While idle, it waits for a start request. A start request clears the counter and flag C and sets flag B. The controller then counts once per clock. The counter value steers the run: the second-highest counter bit decides the new value of B on each count. When the two highest bits are both high, counting ends. One clock later flag C is raised and the controller returns to idle.

The finite state machine comes in two variants, and a parameter selects one of them. The first stores the state in a binary code. The second uses one flip-flop per state. Both variants drive the same counter and flag datapath, and both show the same behaviour at the ports. A host reads the busy output to know when a run has finished. It then reads the final counter value and the flags.

Top module: `seqctl_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces the state to IDLE, the counter to 0, both flags to 0 and `busy_o` to 0.
- R2: In IDLE with `start_i` high, the next edge loads counter 0, B = 1 and C = 0, and enters COUNT. C stays 0 for the whole COUNT phase.
- R3: In COUNT the counter increases by exactly one on every clock edge.
- R4: On each COUNT edge, B takes the value of counter bit CNT_W-2, read before that edge's increment. A 0 in that bit clears B and a 1 sets it.
- R5: A COUNT edge that sees counter bits CNT_W-1 and CNT_W-2 both at 1 (before the increment) moves to DONE. From a start at 0 with CNT_W = 4, this gives 13 COUNT cycles, and the counter reads 13 in DONE.
- R6: DONE lasts exactly one clock. Its edge sets C to 1 and returns to IDLE, and the counter does not change.
- R7: In IDLE with `start_i` low, the state, counter, B and C all keep their values.
- R8: `start_i` has no effect during COUNT or DONE. A start held high through a run gives the same sequence, and the run begins again only from IDLE.
- R9: `state_o` reports IDLE = 0, COUNT = 1 and DONE = 2, and the value 3 never appears. `busy_o` is 1 exactly when the state is not IDLE.
- R10: The binary-coded and one-flip-flop-per-state variants give identical port values on every cycle. In the one-hot variant, exactly one state flip-flop is set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled in IDLE |
| cnt_o | output | CNT_W | Counter value |
| flag_b_o | output | 1 | Flag B, follows the steering bit while counting |
| flag_c_o | output | 1 | Flag C, set when a run completes |
| state_o | output | 2 | State code: 0 IDLE, 1 COUNT, 2 DONE |
| busy_o | output | 1 | High while a run is in progress |

## Verification
Several rules hold on every edge, and the assertions check them cycle by cycle. These are the load on start, the single-step increment, B tracking the steering bit, the stop transition, the one-cycle DONE with C rising, the hold in IDLE, the legal state codes, and the one-hot invariant. Some behaviour shows only over a whole run, so only the bench scenarios can show it. This covers the exact count of 13 cycles before DONE and the final values. It also covers the identical behaviour of the two variants, a start held high across a run, and the restart that follows at once, and a reset that arrives in the middle of a count.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    localparam int ST_W = 2;
    localparam int N_ST = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } state_e;

    // strobes from the state machine to the datapath
    typedef struct packed {
        logic load;    // clear counter and C, set B
        logic step;    // increment and update B
        logic finish;  // raise C
    } ctrl_t;

endpackage

// File: rtl/seqctl_datapath.sv
module seqctl_datapath
    import seqctl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_b_o,
    output logic             flag_c_o
);
    localparam int STEER_LO = CNT_W - 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             b;
        logic             c;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (ctrl_i.load) begin
            dp_d.cnt = '0;
            dp_d.b   = 1'b1;
            dp_d.c   = 1'b0;
        end else if (ctrl_i.step) begin
            dp_d.cnt = dp_q.cnt + CNT_W'(1);
            dp_d.b   = dp_q.cnt[STEER_LO];
        end else if (ctrl_i.finish) begin
            dp_d.c   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign cnt_o    = dp_q.cnt;
    assign flag_b_o = dp_q.b;
    assign flag_c_o = dp_q.c;

endmodule

// File: rtl/seqctl_fsm_bin.sv
module seqctl_fsm_bin
    import seqctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            stop_i,
    output ctrl_t           ctrl_o,
    output logic [ST_W-1:0] state_o
);
    typedef struct packed {
        state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d  = fsm_q;
        ctrl_o = '0;
        case (fsm_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_o.load = 1'b1;
                    fsm_d.st    = ST_COUNT;
                end
            end
            ST_COUNT: begin
                ctrl_o.step = 1'b1;
                if (stop_i) begin
                    fsm_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                ctrl_o.finish = 1'b1;
                fsm_d.st      = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.st <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.st;

endmodule

// File: rtl/seqctl_fsm_onehot.sv
module seqctl_fsm_onehot
    import seqctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            stop_i,
    output ctrl_t           ctrl_o,
    output logic [ST_W-1:0] state_o
);
    localparam int I_IDLE  = int'(ST_IDLE);
    localparam int I_COUNT = int'(ST_COUNT);
    localparam int I_DONE  = int'(ST_DONE);

    typedef struct packed {
        logic [N_ST-1:0] hot;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [N_ST-1:0] hot_q;

    assign hot_q = fsm_q.hot;

    always_comb begin
        fsm_d.hot          = '0;
        fsm_d.hot[I_IDLE]  = (hot_q[I_IDLE] & ~start_i) | hot_q[I_DONE];
        fsm_d.hot[I_COUNT] = (hot_q[I_IDLE] & start_i) | (hot_q[I_COUNT] & ~stop_i);
        fsm_d.hot[I_DONE]  = hot_q[I_COUNT] & stop_i;

        ctrl_o.load   = hot_q[I_IDLE] & start_i;
        ctrl_o.step   = hot_q[I_COUNT];
        ctrl_o.finish = hot_q[I_DONE];

        state_o = ST_IDLE;
        if (hot_q[I_COUNT]) begin
            state_o = ST_COUNT;
        end
        if (hot_q[I_DONE]) begin
            state_o = ST_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.hot <= N_ST'(1) << I_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
    import seqctl_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter bit ONE_HOT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_b_o,
    output logic             flag_c_o,
    output logic [ST_W-1:0]  state_o,
    output logic             busy_o
);
    localparam int STEER_LO = CNT_W - 2;
    localparam int STEER_HI = CNT_W - 1;

    ctrl_t ctrl;
    logic  stop;

    // stop test reads the counter before this edge's increment
    assign stop = cnt_o[STEER_HI] & cnt_o[STEER_LO];

    generate
        if (ONE_HOT) begin : g_oh
            seqctl_fsm_onehot u_fsm (
                .clk     (clk),
                .rst     (rst),
                .start_i (start_i),
                .stop_i  (stop),
                .ctrl_o  (ctrl),
                .state_o (state_o)
            );
        end else begin : g_bin
            seqctl_fsm_bin u_fsm (
                .clk     (clk),
                .rst     (rst),
                .start_i (start_i),
                .stop_i  (stop),
                .ctrl_o  (ctrl),
                .state_o (state_o)
            );
        end
    endgenerate

    seqctl_datapath #(
        .CNT_W (CNT_W)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctrl_i   (ctrl),
        .cnt_o    (cnt_o),
        .flag_b_o (flag_b_o),
        .flag_c_o (flag_c_o)
    );

    assign busy_o = (state_o != ST_IDLE);

endmodule

// File: rtl/seqctl_chk.sv
module seqctl_chk
    import seqctl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             flag_b_o,
    input logic             flag_c_o,
    input logic [ST_W-1:0]  state_o,
    input logic             busy_o
);
    localparam int LO = CNT_W - 2;
    localparam int HI = CNT_W - 1;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_o == ST_IDLE && cnt_o == '0 && !flag_b_o && !flag_c_o && !busy_o)); // R1

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && start_i) |=> (state_o == ST_COUNT && cnt_o == '0 && flag_b_o && !flag_c_o)); // R2

    AST_C_LOW_COUNTING: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_COUNT) |-> !flag_c_o); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_COUNT) |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R3

    AST_B_STEERED: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_COUNT) |=> (flag_b_o == $past(cnt_o[LO]))); // R4

    AST_STOP_ENTERS_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_COUNT && cnt_o[HI] && cnt_o[LO]) |=> (state_o == ST_DONE)); // R5

    AST_KEEP_COUNTING: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_COUNT && !(cnt_o[HI] && cnt_o[LO])) |=> (state_o == ST_COUNT)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DONE) |=> (state_o == ST_IDLE && flag_c_o && $stable(cnt_o))); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && !start_i) |=> (state_o == ST_IDLE && $stable({cnt_o, flag_b_o, flag_c_o}))); // R7

    AST_START_IGNORED_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DONE && start_i) |=> (state_o == ST_IDLE)); // R8

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'd3); // R9

    AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && !start_i) |=> !busy_o); // R9

endmodule

module seqctl_oh_chk
    import seqctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [N_ST-1:0] hot_q
);
    AST_ONE_STATE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(hot_q) == 1); // R10
endmodule

bind seqctl_top seqctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cnt_o    (cnt_o),
    .flag_b_o (flag_b_o),
    .flag_c_o (flag_c_o),
    .state_o  (state_o),
    .busy_o   (busy_o)
);

bind seqctl_fsm_onehot seqctl_oh_chk u_oh_chk (
    .clk   (clk),
    .rst   (rst),
    .hot_q (hot_q)
);

// File: tb/seqctl_top_tb.sv
`timescale 1ns/1ps
module seqctl_top_tb;
    import seqctl_pkg::*;

    localparam int  W        = 4;
    localparam real HALF     = 2.5;
    localparam int  WD_LIMIT = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;

    logic [W-1:0]    cnt_b, cnt_h;
    logic            b_b, b_h, c_b, c_h, busy_b, busy_h;
    logic [ST_W-1:0] st_b, st_h;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(HALF) clk = ~clk;

    seqctl_top #(.CNT_W(W), .ONE_HOT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .cnt_o(cnt_b),
        .flag_b_o(b_b), .flag_c_o(c_b), .state_o(st_b), .busy_o(busy_b));

    seqctl_top #(.CNT_W(W), .ONE_HOT(1'b1)) u_dut_oh (
        .clk(clk), .rst(rst), .start_i(start), .cnt_o(cnt_h),
        .flag_b_o(b_h), .flag_c_o(c_h), .state_o(st_h), .busy_o(busy_h));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // R10: both variants agree at the ports on every cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if ({cnt_b, b_b, c_b, st_b, busy_b} != {cnt_h, b_h, c_h, st_h, busy_h}) begin
                failures++;
                $display("FAIL R10 variant mismatch actual=%0h expected=%0h",
                         {cnt_h, b_h, c_h, st_h, busy_h}, {cnt_b, b_b, c_b, st_b, busy_b});
            end
        end
    end

    task automatic expect_idle_reset(string req);
        chk(req, "state", int'(st_b), 0);
        chk(req, "cnt", int'(cnt_b), 0);
        chk(req, "flag_b", int'(b_b), 0);
        chk(req, "flag_c", int'(c_b), 0);
        chk(req, "busy", int'(busy_b), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        start = 1'b0;
        tick();
        tick();
        expect_idle_reset("R1");
        rst = 1'b0;
    endtask

    // one complete run starting from IDLE; keep_start holds the request high
    task automatic t_run(bit keep_start);
        start = 1'b1;
        tick();
        chk("R2", "state after start", int'(st_b), 1);
        chk("R2", "cnt after start", int'(cnt_b), 0);
        chk("R2", "flag_b after start", int'(b_b), 1);
        chk("R2", "flag_c after start", int'(c_b), 0);
        chk("R9", "busy after start", int'(busy_b), 1);
        if (!keep_start) start = 1'b0;
        for (int k = 0; k <= 12; k++) begin
            tick();
            chk("R3", "cnt step", int'(cnt_b), k + 1);
            chk("R4", "flag_b steer", int'(b_b), (k >> 2) & 1);
            chk("R5", "state while counting", int'(st_b), (k == 12) ? 2 : 1);
            chk("R2", "flag_c low in run", int'(c_b), 0);
            if (keep_start) chk("R8", "start ignored busy", int'(busy_b), 1);
        end
        tick();
        chk("R6", "state after done", int'(st_b), 0);
        chk("R6", "flag_c set", int'(c_b), 1);
        chk("R6", "cnt kept", int'(cnt_b), 13);
        chk("R6", "flag_b final", int'(b_b), 1);
        chk("R9", "busy after done", int'(busy_b), 0);
        if (keep_start) chk("R8", "start ignored in done", int'(st_b), 0);
    endtask

    task automatic t_idle_hold();
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R7", "idle state", int'(st_b), 0);
            chk("R7", "idle cnt", int'(cnt_b), 13);
            chk("R7", "idle flag_b", int'(b_b), 1);
            chk("R7", "idle flag_c", int'(c_b), 1);
        end
    endtask

    task automatic t_midreset();
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        chk("R3", "cnt before reset", int'(cnt_b), 5);
        rst = 1'b1;
        tick();
        expect_idle_reset("R1");
        rst = 1'b0;
        tick();
        chk("R7", "idle after reset", int'(st_b), 0);
    endtask

    initial begin
        t_reset();
        tick();
        t_run(1'b0);
        t_idle_hold();
        t_run(1'b1);
        // start still high in IDLE: a new run begins at once
        t_run(1'b0);
        t_midreset();
        t_run(1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", WD_LIMIT, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule